// File: doc/BRIEF.md
# Write-Stepped Monotonic Event Counter

This block holds a 64-bit event count that can only move forward while it is armed. The count is kept as two 32-bit words, a lower and an upper, that software joins into one value with the upper word as the most significant half. Software arms the counter by setting an enable bit in a mode register. Once armed, each bus write to the lower-word offset adds exactly one to the count, whatever data the write carries. A wrap of the lower word carries into the upper word.

While the counter is disarmed, software may preload either word with any value. Counting is refused while the external `timeInvalid` input is high, and also after the full 64-bit count has wrapped. That wrap raises a sticky overflow flag, which only a reset clears. Access goes through a simple synchronous bus: one write or one read per cycle, with read data returned one cycle after the request.

Top module: `mono_counter`

## Requirements
- R1: After reset both words, the enable bit and the overflow flag are zero, so reads of offsets 0, 1 and 2 return zero.
- R2: Offset 0 is the mode register: bit 0 is the enable bit and can be written; bit 1 is the overflow flag and reads back but ignores writes. All other bits read as zero.
- R3: With enable clear, a write to offset 1 loads the lower word and a write to offset 2 loads the upper word with the write data.
- R4: With enable set, a write to offset 1 adds one to the 64-bit count and its write data has no effect.
- R5: When an increment finds the lower word at all ones, the lower word becomes zero and the upper word goes up by one.
- R6: With enable set, a write to offset 2 leaves the upper word unchanged.
- R7: While `timeInvalid` is high, a write to offset 1 with enable set leaves both words unchanged.
- R8: An increment with both words at all ones sets both words to zero and sets the overflow flag.
- R9: Once the overflow flag is set it stays set until reset, and further increment writes leave both words unchanged.
- R10: `rdValid` is high exactly one cycle after a cycle with `rdEn` high, and `rdData` then holds the register addressed in that request cycle.
- R11: A read of offset 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| timeInvalid | input | 1 | When high, increments are refused |
| wrEn | input | 1 | Write strobe for this cycle |
| rdEn | input | 1 | Read request for this cycle |
| addr | input | 2 | Register offset: 0 mode, 1 lower word, 2 upper word, 3 spare |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid while rdValid is high |
| rdValid | output | 1 | Read data valid, one cycle after rdEn |

## Verification
The assertions assume that `wrEn` and `rdEn` are never high in the same cycle, and that `timeInvalid` changes only between bus operations. The bench drives every bus operation from one task at a time, on the falling clock edge. It keeps `timeInvalid` steady for the whole of each write. Reads are issued only in cycles with no write, so each read sees state that no other operation is changing.

// File: rtl/mono_pkg.sv
package mono_pkg;
  localparam int ADDR_W    = 2;
  localparam int NUM_WORDS = 2;
  localparam int EN_BIT    = 0;
  localparam int OVF_BIT   = 1;

  typedef enum logic [ADDR_W-1:0] {
    REG_MODE  = 2'd0,
    REG_LO    = 2'd1,
    REG_HI    = 2'd2,
    REG_SPARE = 2'd3
  } regSel_e;

  typedef struct packed {
    logic [NUM_WORDS-1:0] loadWord;
    logic                 incr;
    logic                 rdReq;
    regSel_e              rdSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/mono_ctrl.sv
module mono_ctrl
  import mono_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              enWrBit,
  input  logic              timeInvalid,
  input  logic              allOnes,
  output ctrlStrobe_t       strobe,
  output logic              enable,
  output logic              ovfFlag
);
  regSel_e sel;
  logic    modeWr;

  assign sel    = regSel_e'(addr);
  assign modeWr = wrEn && (sel == REG_MODE);

  always_comb begin
    strobe             = '0;
    strobe.loadWord[0] = wrEn && (sel == REG_LO) && !enable;
    strobe.loadWord[1] = wrEn && (sel == REG_HI) && !enable;
    strobe.incr        = wrEn && (sel == REG_LO) && enable && !timeInvalid && !ovfFlag;
    strobe.rdReq       = rdEn;
    strobe.rdSel       = sel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable  <= 1'b0;
      ovfFlag <= 1'b0;
    end else begin
      if (modeWr) enable <= enWrBit;
      if (strobe.incr && allOnes) ovfFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/mono_datapath.sv
module mono_datapath
  import mono_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [WORD_W-1:0] wrData,
  input  logic              enable,
  input  logic              ovfFlag,
  output logic              allOnes,
  output logic [WORD_W-1:0] loWord,
  output logic [WORD_W-1:0] hiWord,
  output logic [WORD_W-1:0] rdData,
  output logic              rdValid
);
  logic [WORD_W-1:0] words [NUM_WORDS];
  logic [NUM_WORDS:0] carry;

  assign carry[0] = strobe.incr;

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    assign carry[i+1] = carry[i] && (&words[i]);
    always_ff @(posedge clk) begin
      if (!rstN)                   words[i] <= '0;
      else if (strobe.loadWord[i]) words[i] <= wrData;
      else if (carry[i])           words[i] <= words[i] + 1'b1;
    end
  end

  assign loWord  = words[0];
  assign hiWord  = words[1];
  assign allOnes = (&words[0]) && (&words[1]);

  logic [WORD_W-1:0] modeView;
  always_comb begin
    modeView          = '0;
    modeView[EN_BIT]  = enable;
    modeView[OVF_BIT] = ovfFlag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobe.rdReq;
      if (strobe.rdReq) begin
        case (strobe.rdSel)
          REG_MODE: rdData <= modeView;
          REG_LO:   rdData <= words[0];
          REG_HI:   rdData <= words[1];
          default:  rdData <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/mono_counter.sv
module mono_counter
  import mono_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              timeInvalid,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData,
  output logic              rdValid
);
  ctrlStrobe_t       strobe;
  logic              enable;
  logic              ovfFlag;
  logic              allOnes;
  logic [WORD_W-1:0] loWord;
  logic [WORD_W-1:0] hiWord;

  mono_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .enWrBit(wrData[EN_BIT]), .timeInvalid(timeInvalid), .allOnes(allOnes),
    .strobe(strobe), .enable(enable), .ovfFlag(ovfFlag)
  );

  mono_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .enable(enable), .ovfFlag(ovfFlag), .allOnes(allOnes),
    .loWord(loWord), .hiWord(hiWord), .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: rtl/mono_counter_chk.sv
module mono_counter_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              timeInvalid,
  input logic              wrEn,
  input logic              rdEn,
  input logic [1:0]        addr,
  input logic              rdValid,
  input logic              enable,
  input logic              ovfFlag,
  input logic [WORD_W-1:0] loWord,
  input logic [WORD_W-1:0] hiWord
);
  logic incWr, loFull, hiFull;
  assign incWr  = wrEn && (addr == 2'd1) && enable;
  assign loFull = &loWord;
  assign hiFull = &hiWord;

  p_rd_valid_r10: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);
  p_rd_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> !rdValid);
  p_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (incWr && !timeInvalid && !ovfFlag && !loFull)
      |=> (loWord == $past(loWord) + 1'b1) && $stable(hiWord));
  p_carry_r5: assert property (@(posedge clk) disable iff (!rstN)
    (incWr && !timeInvalid && !ovfFlag && loFull && !hiFull)
      |=> (loWord == '0) && (hiWord == $past(hiWord) + 1'b1));
  p_hi_locked_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (addr == 2'd2) && enable) |=> $stable(hiWord));
  p_no_count_r7: assert property (@(posedge clk) disable iff (!rstN)
    (incWr && timeInvalid) |=> $stable(loWord) && $stable(hiWord));
  p_wrap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (incWr && !timeInvalid && !ovfFlag && loFull && hiFull)
      |=> (loWord == '0) && (hiWord == '0) && ovfFlag);
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag |=> ovfFlag);
  p_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    (incWr && ovfFlag) |=> $stable(loWord) && $stable(hiWord));
endmodule

bind mono_counter mono_counter_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rstN(rstN), .timeInvalid(timeInvalid), .wrEn(wrEn), .rdEn(rdEn),
  .addr(addr), .rdValid(rdValid), .enable(enable), .ovfFlag(ovfFlag),
  .loWord(loWord), .hiWord(hiWord)
);

// File: tb/test_mono_counter.sv
module test_mono_counter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        timeInvalid = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        rdValid;

  int total = 0;
  int bad = 0;
  logic [31:0] expQ [$];
  string       tagQ [$];

  always #10 clk = ~clk;

  mono_counter i_mono_counter (
    .clk(clk), .rstN(rstN), .timeInvalid(timeInvalid), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .rdValid(rdValid)
  );

  task automatic busWrite(input logic [1:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, input logic [31:0] exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    total++;
    if (rdValid !== 1'b1) begin
      bad++;
      $display("FAIL R10 rdValid after request: actual=%b expected=1", rdValid);
    end
  endtask

  // monitor: pops one expected item for every returned read
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      total++;
      if (expQ.size() == 0) begin
        bad++;
        $display("FAIL R10 unexpected read data: actual=%h expected=none", rdData);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (rdData !== e) begin
          bad++;
          $display("FAIL %s: actual=%h expected=%h", t, rdData, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R10: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state, R11 spare offset
    busRead(2'd0, 32'h0, "R1 mode");
    busRead(2'd1, 32'h0, "R1 low");
    busRead(2'd2, 32'h0, "R1 high");
    busRead(2'd3, 32'h0, "R11 spare");
    // R3 direct loads while disarmed
    busWrite(2'd1, 32'h1234_5678);
    busWrite(2'd2, 32'hA5A5_0001);
    busRead(2'd1, 32'h1234_5678, "R3 low load");
    busRead(2'd2, 32'hA5A5_0001, "R3 high load");
    // R2 flag bit not writable
    busWrite(2'd0, 32'h0000_0003);
    busRead(2'd0, 32'h0000_0001, "R2 mode");
    // R4 increments ignore data
    busWrite(2'd1, 32'hDEAD_0000);
    busRead(2'd1, 32'h1234_5679, "R4 first step");
    busWrite(2'd1, 32'h0000_0000);
    busRead(2'd1, 32'h1234_567A, "R4 second step");
    busRead(2'd2, 32'hA5A5_0001, "R4 high unchanged");
    // R6 high word locked while armed
    busWrite(2'd2, 32'h0000_0000);
    busRead(2'd2, 32'hA5A5_0001, "R6 high write ignored");
    // R7 time invalid inhibits
    timeInvalid = 1'b1;
    busWrite(2'd1, 32'h0);
    timeInvalid = 1'b0;
    busRead(2'd1, 32'h1234_567A, "R7 low held");
    busRead(2'd2, 32'hA5A5_0001, "R7 high held");
    // R5 carry
    busWrite(2'd0, 32'h0);
    busWrite(2'd1, 32'hFFFF_FFFF);
    busWrite(2'd2, 32'h0000_0005);
    busWrite(2'd0, 32'h1);
    busWrite(2'd1, 32'h0);
    busRead(2'd1, 32'h0, "R5 low wrapped");
    busRead(2'd2, 32'h6, "R5 high carried");
    // R8 full wrap
    busWrite(2'd0, 32'h0);
    busWrite(2'd1, 32'hFFFF_FFFF);
    busWrite(2'd2, 32'hFFFF_FFFF);
    busWrite(2'd0, 32'h1);
    busWrite(2'd1, 32'h0);
    busRead(2'd1, 32'h0, "R8 low zero");
    busRead(2'd2, 32'h0, "R8 high zero");
    busRead(2'd0, 32'h3, "R8 flag set");
    // R9 frozen and sticky
    busWrite(2'd1, 32'h0);
    busRead(2'd1, 32'h0, "R9 no further count");
    busWrite(2'd0, 32'h0);
    busRead(2'd0, 32'h2, "R9 flag sticky");
    busRead(2'd3, 32'h0, "R11 spare again");
    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      total++; bad++;
      $display("FAIL R10 missing reads: actual=%0d expected=0", expQ.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule